// File: doc/BRIEF.md
# Piecewise-Linear Square Root Evaluator

This block returns an approximate square root of an unsigned fixed-point magnitude. It is intended for the magnitude stage of a Box-Muller Gaussian noise source. The operand is an unsigned 31-bit word with 24 fractional bits, so it covers [0, 128). The result is an unsigned 28-bit word with 4 integer bits and 24 fractional bits.

Evaluation runs in three steps:

1. The operand is shifted left by an even number of bit positions, so that the value lands in [1, 4) and the exponent halves exactly.
2. The reduced value is looked up in one of two 64-entry chord tables, one for [1, 2) and one for [2, 4), and interpolated linearly.
3. The result is scaled back by a shift equal to half the normalising shift.

The block accepts one operand per clock and has a fixed latency of two cycles. Valid travels alongside the data.

Top module: `sqrt_pwl_eval`

## Requirements
- R1: `in_data` is read as unsigned with 24 fractional bits. `out_data` is unsigned with 24 fractional bits, so an operand of 1.0 (0x1000000) gives 1.0 and an operand of 4.0 gives 2.0.
- R2: The operand is zero-extended to 32 bits and shifted left by an even amount, so that bits 31:30 of the reduced word are not both zero. Shifting the reduced word back right by the same amount restores the operand.
- R3: The reduced word carries 30 fractional bits. When bit 31 is set, the [2, 4) table is used, addressed by bits 30:25. Otherwise the [1, 2) table is used, addressed by bits 29:24. An operand that falls exactly on a segment start of either table yields exactly floor(sqrt(in_data * 2^24)).
- R4: For any nonzero operand, with E = floor(sqrt(in_data * 2^24)), the result satisfies out_data <= E and E - out_data <= (E >> 15) + 2.
- R5: An operand of zero yields a result of zero.
- R6: `out_vld` is `in_vld` delayed by exactly two cycles. `out_data` belongs to the operand presented with that `in_vld`, and back-to-back operands give back-to-back results.
- R7: While reset is active and just after it ends, `out_vld` and `out_data` are zero.
- R8: The largest operand (0x7FFFFFFF) gives a result within the R4 bound and never above 189812532. The smallest nonzero operand (1) gives exactly 4096.
- R9: While `in_vld` is low, `in_data` is ignored, and `out_data` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operand present this cycle |
| in_data | input | 31 | Operand, unsigned, 24 fractional bits |
| out_vld | output | 1 | Result present this cycle |
| out_data | output | 28 | Result, unsigned, 24 fractional bits |

## Verification
An operand presented before rising edge N is captured at edge N and its result appears at edge N+2. The bench drives inputs on falling edges and reads `out_vld` and `out_data` at the falling edge after the second rising edge. Every valid result is therefore checked exactly two cycles after its operand. In the streaming test one new operand is driven each cycle, and each sample is compared against the operand driven two falling edges earlier. A further sample one cycle later must show `out_vld` low again.

// File: rtl/sqrt_pwl_pkg.sv
package sqrt_pwl_pkg;

    localparam int IN_W     = 31;
    localparam int IN_FRAC  = 24;
    localparam int NORM_W   = IN_W + 1;
    localparam int PAIRS    = NORM_W / 2;
    localparam int HALF_W   = $clog2(PAIRS);
    localparam int SEG_BITS = 6;
    localparam int SEG_N    = 1 << SEG_BITS;
    localparam int FRAC_W   = NORM_W - 2 - SEG_BITS;
    localparam int Y_FRAC   = IN_FRAC + (NORM_W - 2 - IN_FRAC) / 2;
    localparam int Y_W      = Y_FRAC + 1;
    localparam int D_W      = 22;
    localparam int OUT_W    = Y_W;
    localparam int LO_SH    = 2 * Y_FRAC - SEG_BITS;
    localparam int HI_SH    = LO_SH + 1;

    localparam logic [OUT_W-1:0] OUT_MAX = OUT_W'(189812532);

    // floor square root, bit by bit, used for building the chord tables
    function automatic logic [31:0] isqrt64(input logic [63:0] v);
        logic [31:0] root;
        logic [63:0] trial;
        root = '0;
        for (int b = 31; b >= 0; b--) begin
            trial = {32'd0, root | (32'd1 << b)};
            if (trial * trial <= v)
                root = root | (32'd1 << b);
        end
        return root;
    endfunction

    typedef struct packed {
        logic                s1_vld;
        logic [NORM_W-1:0]   s1_norm;
        logic [HALF_W-1:0]   s1_half;
        logic                s1_zero;
        logic                o_vld;
        logic [OUT_W-1:0]    o_data;
    } pipe_t;

endpackage

// File: rtl/sqrt_pwl_norm.sv
module sqrt_pwl_norm
    import sqrt_pwl_pkg::*;
(
    input  logic [IN_W-1:0]   x,
    output logic [NORM_W-1:0] norm,
    output logic [HALF_W-1:0] half,
    output logic              zero
);

    logic [NORM_W-1:0] wide;
    logic [HALF_W-1:0] top_pair;

    // highest bit pair holding a one decides the even shift
    always_comb begin
        wide     = {{(NORM_W-IN_W){1'b0}}, x};
        top_pair = '0;
        for (int k = 0; k < PAIRS; k++) begin
            if (wide[2*k+1 -: 2] != 2'b00)
                top_pair = HALF_W'(k);
        end
        half = HALF_W'(PAIRS - 1) - top_pair;
        norm = wide << {half, 1'b0};
        zero = (x == '0);
    end

endmodule

// File: rtl/sqrt_pwl_rom.sv
module sqrt_pwl_rom
    import sqrt_pwl_pkg::*;
(
    input  logic                sel_hi,
    input  logic [SEG_BITS-1:0] idx,
    output logic [Y_W-1:0]      base,
    output logic [D_W-1:0]      delta
);

    logic [Y_W-1:0] lo_base  [SEG_N];
    logic [D_W-1:0] lo_delta [SEG_N];
    logic [Y_W-1:0] hi_base  [SEG_N];
    logic [D_W-1:0] hi_delta [SEG_N];

    // chord endpoints of sqrt on [1,2) and [2,4), Q1.Y_FRAC
    for (genvar i = 0; i < SEG_N; i++) begin : g_seg
        localparam logic [31:0] LO_A = isqrt64(64'(SEG_N + i)     << LO_SH);
        localparam logic [31:0] LO_B = isqrt64(64'(SEG_N + i + 1) << LO_SH);
        localparam logic [31:0] HI_A = isqrt64(64'(SEG_N + i)     << HI_SH);
        localparam logic [31:0] HI_B = isqrt64(64'(SEG_N + i + 1) << HI_SH);
        assign lo_base[i]  = Y_W'(LO_A);
        assign lo_delta[i] = D_W'(LO_B - LO_A);
        assign hi_base[i]  = Y_W'(HI_A);
        assign hi_delta[i] = D_W'(HI_B - HI_A);
    end

    always_comb begin
        if (sel_hi) begin
            base  = hi_base[idx];
            delta = hi_delta[idx];
        end else begin
            base  = lo_base[idx];
            delta = lo_delta[idx];
        end
    end

endmodule

// File: rtl/sqrt_pwl_interp.sv
module sqrt_pwl_interp
    import sqrt_pwl_pkg::*;
(
    input  logic [Y_W-1:0]    base,
    input  logic [D_W-1:0]    delta,
    input  logic [FRAC_W-1:0] frac,
    input  logic [HALF_W-1:0] half,
    output logic [OUT_W-1:0]  res
);

    localparam int PROD_W = D_W + FRAC_W;
    localparam int R_W    = Y_W + 1;
    localparam int WIDE_W = R_W + PAIRS - 1;

    logic [PROD_W-1:0] prod;
    logic [R_W-1:0]    root;
    logic [HALF_W-1:0] shl;
    logic [WIDE_W-1:0] wide;

    // linear step within the segment, then reconstruct by a left shift
    // of the complement of the half shift followed by a fixed slice
    always_comb begin
        prod = PROD_W'(delta) * PROD_W'(frac);
        root = R_W'(base) + R_W'(prod >> FRAC_W);
        shl  = HALF_W'(PAIRS - 1) - half;
        wide = WIDE_W'(root) << shl;
        res  = OUT_W'(wide >> (PAIRS - 1));
    end

endmodule

// File: rtl/sqrt_pwl_eval.sv
module sqrt_pwl_eval
    import sqrt_pwl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_vld,
    output logic [OUT_W-1:0] out_data
);

    pipe_t q, d;

    logic [NORM_W-1:0]   nrm_word;
    logic [HALF_W-1:0]   nrm_half;
    logic                nrm_zero;
    logic                seg_hi;
    logic [SEG_BITS-1:0] seg_idx;
    logic [FRAC_W-1:0]   seg_frac;
    logic [Y_W-1:0]      seg_base;
    logic [D_W-1:0]      seg_delta;
    logic [OUT_W-1:0]    itp_res;

    sqrt_pwl_norm u_norm (
        .x    (in_data),
        .norm (nrm_word),
        .half (nrm_half),
        .zero (nrm_zero)
    );

    // field split of the registered reduced word
    always_comb begin
        seg_hi = q.s1_norm[NORM_W-1];
        if (seg_hi) begin
            seg_idx  = q.s1_norm[NORM_W-2 -: SEG_BITS];
            seg_frac = q.s1_norm[NORM_W-2-SEG_BITS -: FRAC_W];
        end else begin
            seg_idx  = q.s1_norm[NORM_W-3 -: SEG_BITS];
            seg_frac = q.s1_norm[NORM_W-3-SEG_BITS -: FRAC_W];
        end
    end

    sqrt_pwl_rom u_rom (
        .sel_hi (seg_hi),
        .idx    (seg_idx),
        .base   (seg_base),
        .delta  (seg_delta)
    );

    sqrt_pwl_interp u_interp (
        .base  (seg_base),
        .delta (seg_delta),
        .frac  (seg_frac),
        .half  (q.s1_half),
        .res   (itp_res)
    );

    always_comb begin
        d        = q;
        d.s1_vld = in_vld;
        if (in_vld) begin
            d.s1_norm = nrm_word;
            d.s1_half = nrm_half;
            d.s1_zero = nrm_zero;
        end
        d.o_vld = q.s1_vld;
        if (q.s1_vld)
            d.o_data = q.s1_zero ? '0 : itp_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign out_vld  = q.o_vld;
    assign out_data = q.o_data;

    AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ##2 out_vld); // R6
    AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |-> ##2 !out_vld); // R6
    AST_REDUCED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1_vld && !q.s1_zero) |-> (q.s1_norm[NORM_W-1 -: 2] != 2'b00)); // R2
    AST_EVEN_UNDO: assert property (@(posedge clk) disable iff (!rst_n)
        q.s1_vld |-> ((q.s1_norm >> {q.s1_half, 1'b0}) == {1'b0, $past(in_data)})); // R2
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1_vld && q.s1_zero) |=> (out_data == '0)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_data <= OUT_MAX)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !q.s1_vld |=> $stable(out_data)); // R9

endmodule

// File: tb/sqrt_pwl_eval_test.sv
`timescale 1ns/1ps
module sqrt_pwl_eval_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [30:0] in_data = '0;
    logic        out_vld;
    logic [27:0] out_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sqrt_pwl_eval uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_data  (in_data),
        .out_vld  (out_vld),
        .out_data (out_data)
    );

    // remainder-style floor square root, independent reference
    function automatic longint unsigned ref_root(input longint unsigned v);
        longint unsigned op = v;
        longint unsigned res = 0;
        longint unsigned one = 64'h4000_0000_0000_0000;
        while (one > op) one = one >> 2;
        while (one != 0) begin
            if (op >= res + one) begin
                op  = op - (res + one);
                res = (res >> 1) + one;
            end else begin
                res = res >> 1;
            end
            one = one >> 2;
        end
        return res;
    endfunction

    function automatic longint unsigned exact_of(input logic [30:0] x);
        return ref_root(longint'(x) << 24);
    endfunction

    task automatic check_eq(input string req, input longint unsigned got,
                            input longint unsigned exp, input logic [30:0] x);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s in=0x%08h actual=%0d expected=%0d", req, x, got, exp);
        end
    endtask

    task automatic check_bound(input string req, input longint unsigned got,
                               input logic [30:0] x);
        longint unsigned e = exact_of(x);
        total++;
        if (got > e || (e - got) > (e >> 15) + 2) begin
            bad++;
            $display("FAIL %s in=0x%08h actual=%0d expected=%0d (tolerance %0d below)",
                     req, x, got, e, (e >> 15) + 2);
        end
    endtask

    // one operand, result read two rising edges later
    task automatic run_one(input logic [30:0] x, output logic v, output logic [27:0] y);
        @(negedge clk);
        in_vld  = 1'b1;
        in_data = x;
        @(negedge clk);
        in_vld  = 1'b0;
        @(negedge clk);
        v = out_vld;
        y = out_data;
    endtask

    task automatic t_reset;
        rst_n  = 1'b0;
        in_vld = 1'b1;
        in_data = 31'h0123_4567;
        repeat (3) @(negedge clk);
        check_eq("R7 vld in reset", out_vld, 0, in_data);
        check_eq("R7 data in reset", out_data, 0, in_data);
        in_vld = 1'b0;
        rst_n  = 1'b1;
        @(negedge clk);
        check_eq("R7 vld after reset", out_vld, 0, in_data);
        check_eq("R7 data after reset", out_data, 0, in_data);
    endtask

    task automatic t_formats;
        logic v;
        logic [27:0] y;
        run_one(31'h100_0000, v, y);
        check_eq("R1 vld", v, 1, 31'h100_0000);
        check_eq("R1 one", y, 28'h100_0000, 31'h100_0000);
        run_one(31'h400_0000, v, y);
        check_eq("R1 four", y, 28'h200_0000, 31'h400_0000);
        run_one(31'h900_0000, v, y);
        check_eq("R1 nine", y, 28'h300_0000, 31'h900_0000);
    endtask

    task automatic t_breakpoints;
        int seg_list[6] = '{0, 1, 17, 31, 46, 63};
        int lo_sh[4] = '{0, 8, 18, 24};
        int hi_sh[4] = '{1, 9, 19, 23};
        logic v;
        logic [27:0] y;
        logic [30:0] x;
        foreach (seg_list[a]) begin
            for (int b = 0; b < 4; b++) begin
                x = 31'(64 + seg_list[a]) << lo_sh[b];
                run_one(x, v, y);
                check_eq("R3 low table start", y, exact_of(x), x);
                x = 31'(64 + seg_list[a]) << hi_sh[b];
                run_one(x, v, y);
                check_eq("R3 high table start", y, exact_of(x), x);
            end
        end
    endtask

    task automatic t_between;
        logic [30:0] fixed_list[8] = '{31'd3, 31'd5, 31'd12345, 31'h0123_4567,
                                       31'h5A5A_5A5A, 31'h0000_FFFF, 31'h2AAA_AAAA,
                                       31'h017F_FFFF};
        logic [31:0] lfsr = 32'hACE1_2468;
        logic v;
        logic [27:0] y;
        logic [30:0] x;
        foreach (fixed_list[k]) begin
            run_one(fixed_list[k], v, y);
            check_bound("R4 fixed pattern", y, fixed_list[k]);
        end
        for (int n = 0; n < 300; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            x = lfsr[30:0] >> (lfsr[31:27] % 31);
            if (x == '0) x = 31'd7;
            run_one(x, v, y);
            check_bound("R4 sweep", y, x);
        end
    endtask

    task automatic t_zero;
        logic v;
        logic [27:0] y;
        run_one(31'h7FFF_FFFF, v, y);
        run_one(31'd0, v, y);
        check_eq("R5 vld", v, 1, 31'd0);
        check_eq("R5 zero", y, 0, 31'd0);
    endtask

    task automatic t_extremes;
        logic v;
        logic [27:0] y;
        run_one(31'h7FFF_FFFF, v, y);
        check_bound("R8 max operand", y, 31'h7FFF_FFFF);
        total++;
        if (y > 28'd189812532) begin
            bad++;
            $display("FAIL R8 ceiling actual=%0d expected<=189812532", y);
        end
        run_one(31'd1, v, y);
        check_eq("R8 min operand", y, 4096, 31'd1);
    endtask

    task automatic t_stream;
        logic [30:0] seq[8] = '{31'h100_0000, 31'd1, 31'h7FFF_FFFF, 31'd0,
                                31'h900_0000, 31'h0123_4567, 31'd2, 31'h400_0000};
        for (int c = 0; c < 11; c++) begin
            @(negedge clk);
            if (c >= 2 && c < 10) begin
                check_eq("R6 stream vld", out_vld, 1, seq[c-2]);
                if (seq[c-2] == '0)
                    check_eq("R6 stream zero", out_data, 0, seq[c-2]);
                else
                    check_bound("R6 stream data", out_data, seq[c-2]);
            end
            if (c == 10)
                check_eq("R6 stream end", out_vld, 0, 31'd0);
            if (c < 8) begin
                in_vld  = 1'b1;
                in_data = seq[c];
            end else begin
                in_vld = 1'b0;
            end
        end
    endtask

    task automatic t_idle_hold;
        logic v;
        logic [27:0] y;
        run_one(31'h0123_4567, v, y);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            in_data = 31'(32'h1111_1111 * (c + 3));
            check_eq("R9 idle vld", out_vld, 0, in_data);
            check_eq("R9 idle data", out_data, y, in_data);
        end
    endtask

    initial begin
        t_reset();
        t_formats();
        t_breakpoints();
        t_between();
        t_zero();
        t_extremes();
        t_stream();
        t_idle_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule